// File: doc/BRIEF.md
# Diminished-1 Carry-Save Residue Codec

This block sits at the two edges of a residue datapath that works modulo a Fermat-style modulus 2^N+1. On the way in, an ordinary (N+1)-bit binary residue is split into a pair of N-bit words (s, c). Each word carries diminished-1 meaning, so downstream adders and compressors never need to detect a zero operand. The split is free: s is the low part of the input, and c is all ones except one inverted bit.

On the way out, a pair is folded back into one residue. A parallel-prefix adder sums s and c with an inverted end-around carry. It flags the single pattern that stands for zero. Its diminished-1 result is then raised by one into an ordinary binary residue in the range 0 to 2^N. The result is captured in one output register, qualified by a valid strobe. This decode is the only point in such a datapath where carry propagation and zero handling are paid for.

Top module: `dm1_codec`

## Requirements
- R1: The encoder's s output equals the low N bits of the binary input. For N=4, input 13 gives s=1101.
- R2: Bit 0 of the encoder's c output is the inverse of the input's top bit (bit N), and every other bit of c is 1. For N=4, input 13 gives c=1111 and input 16 gives s=0000, c=1110.
- R3: A pair (s, c) represents the residue ((s+1)+(c+1)) mod (2^N+1). For every input 0..2^N, the encoded pair represents the input. For N=4, input 0 gives s=0000, c=1111.
- R4: For any pair presented with the decode strobe high, the decoded output equals ((s+1)+(c+1)) mod (2^N+1), written as an (N+1)-bit binary number.
- R5: The decoded output always lies in 0..2^N. A pair whose s and c differ in every bit decodes to 0. For N=4, s=0000 with c=1111 gives 0. A pair whose value is 2^N decodes to binary 1_000...0.
- R6: For N = 1, 2, 4 and 8, encoding any residue 0..2^N and then decoding the resulting pair returns that residue unchanged.
- R7: The decoded result and its valid flag appear one clock after the strobed inputs. Results come out in the order the pairs were presented.
- R8: While the decode strobe is low, the decoded output holds its last value regardless of the pair inputs, and the valid flag is low.
- R9: While reset is asserted, and immediately after it, the valid flag is 0 and the decoded output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_bin_i | input | N+1 | Binary residue to encode (0..2^N) |
| enc_s_o | output | N | Sum half of the encoded pair |
| enc_c_o | output | N | Carry half of the encoded pair |
| dec_vld_i | input | 1 | Strobe: pair on dec_s_i/dec_c_i is to be decoded |
| dec_s_i | input | N | Sum half of the pair to decode |
| dec_c_i | input | N | Carry half of the pair to decode |
| dec_vld_o | output | 1 | Decoded result valid |
| dec_bin_o | output | N+1 | Decoded binary residue (0..2^N) |

## Verification
The bench sweeps every residue through encode and decode at four widths, including N=1, where the prefix tree has no levels and c is a single inverted bit. If the inverted carry were placed in the wrong bit, 2^N would come back wrong. It also drives all 256 pairs at N=4, which covers the all-propagate pattern that must give 0, and the sums that wrap past the modulus. A decoder that fed the end-around carry without inverting it, or that dropped the zero flag, would return 2^N+1 or an off-by-one value on exactly those pairs. Finally, it changes the pair with the strobe low and checks that the output does not move.

// File: rtl/dm1_pkg.sv
package dm1_pkg;

  // Number of Kogge-Stone combine levels for a w-bit prefix network.
  function automatic int unsigned prefix_levels(input int unsigned w);
    if (w <= 1) return 0;
    return $clog2(w);
  endfunction

endpackage

// File: rtl/dm1_encode.sv
module dm1_encode #(
  parameter int unsigned N = 4
) (
  input  logic [N:0]   bin_i,
  output logic [N-1:0] s_o,
  output logic [N-1:0] c_o
);

  // Low part passes straight through; the top bit only steers c[0].
  assign s_o = bin_i[N-1:0];

  generate
    if (N > 1) begin : g_wide
      assign c_o = {{(N-1){1'b1}}, ~bin_i[N]};
    end else begin : g_narrow
      assign c_o = ~bin_i[N];
    end
  endgenerate

endmodule

// File: rtl/dm1_prefix_add.sv
module dm1_prefix_add #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] d_o,
  output logic         zero_o
);
  import dm1_pkg::*;

  localparam int unsigned LV = prefix_levels(N);

  genvar k, i;
  generate
    for (k = 0; k <= LV; k++) begin : lvl
      logic [N-1:0] g;
      logic [N-1:0] p;
      if (k == 0) begin : g_base
        assign g = a_i & b_i;
        assign p = a_i ^ b_i;
      end else begin : g_comb
        localparam int unsigned DIST = 1 << (k - 1);
        for (i = 0; i < N; i++) begin : bitn
          if (i >= DIST) begin : g_join
            assign g[i] = lvl[k-1].g[i] | (lvl[k-1].p[i] & lvl[k-1].g[i-DIST]);
            assign p[i] = lvl[k-1].p[i] & lvl[k-1].p[i-DIST];
          end else begin : g_pass
            assign g[i] = lvl[k-1].g[i];
            assign p[i] = lvl[k-1].p[i];
          end
        end
      end
    end
  endgenerate

  // Group terms spanning bit 0 up to each position.
  logic [N-1:0] grp_g;
  logic [N-1:0] grp_p;
  logic         cin_eac;
  logic [N-1:0] carry;

  assign grp_g   = lvl[LV].g;
  assign grp_p   = lvl[LV].p;
  // Inverted end-around carry re-enters at every position in one step.
  assign cin_eac = ~grp_g[N-1];

  generate
    for (i = 0; i < N; i++) begin : g_cin
      if (i == 0) begin : g_lsb
        assign carry[i] = cin_eac;
      end else begin : g_up
        assign carry[i] = grp_g[i-1] | (grp_p[i-1] & cin_eac);
      end
    end
  endgenerate

  assign d_o    = lvl[0].p ^ carry;
  // All positions propagate: raw sum is 2^N-1, the pair stands for 0.
  assign zero_o = grp_p[N-1];

endmodule

// File: rtl/dm1_to_binary.sv
module dm1_to_binary #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] d_i,
  input  logic         zero_i,
  output logic [N:0]   bin_o
);

  logic [N:0] raised;

  assign raised = {1'b0, d_i} + {{N{1'b0}}, 1'b1};
  assign bin_o  = zero_i ? '0 : raised;

endmodule

// File: rtl/dm1_codec.sv
module dm1_codec #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N:0]   enc_bin_i,
  output logic [N-1:0] enc_s_o,
  output logic [N-1:0] enc_c_o,
  input  logic         dec_vld_i,
  input  logic [N-1:0] dec_s_i,
  input  logic [N-1:0] dec_c_i,
  output logic         dec_vld_o,
  output logic [N:0]   dec_bin_o
);

  logic [N-1:0] sum_d1;
  logic         sum_zero;
  logic [N:0]   sum_bin;
  logic [N:0]   res_d, res_q;
  logic         vld_d, vld_q;

  dm1_encode #(.N(N)) u_enc (
    .bin_i (enc_bin_i),
    .s_o   (enc_s_o),
    .c_o   (enc_c_o)
  );

  dm1_prefix_add #(.N(N)) u_add (
    .a_i    (dec_s_i),
    .b_i    (dec_c_i),
    .d_o    (sum_d1),
    .zero_o (sum_zero)
  );

  dm1_to_binary #(.N(N)) u_conv (
    .d_i    (sum_d1),
    .zero_i (sum_zero),
    .bin_o  (sum_bin)
  );

  always_comb begin
    vld_d = dec_vld_i;
    res_d = res_q;
    if (dec_vld_i) res_d = sum_bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign dec_vld_o = vld_q;
  assign dec_bin_o = res_q;

endmodule

// File: rtl/dm1_codec_chk.sv
module dm1_codec_chk #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N:0]   enc_bin_i,
  input logic [N-1:0] enc_s_o,
  input logic [N-1:0] enc_c_o,
  input logic         dec_vld_i,
  input logic [N-1:0] dec_s_i,
  input logic [N-1:0] dec_c_i,
  input logic         dec_vld_o,
  input logic [N:0]   dec_bin_o
);

  localparam int unsigned MOD = (32'd1 << N) + 32'd1;

  function automatic int unsigned pair_val(input int unsigned s, input int unsigned c);
    return ((s + 32'd1) + (c + 32'd1)) % MOD;
  endfunction

  // R3
  enc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(enc_bin_i) < MOD) |-> (pair_val(32'(enc_s_o), 32'(enc_c_o)) == 32'(enc_bin_i)));

  // R4
  dec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dec_vld_i)) |->
      (32'(dec_bin_o) == pair_val(32'($past(dec_s_i)), 32'($past(dec_c_i)))));

  // R5
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> (32'(dec_bin_o) < MOD));

  // R7
  dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dec_vld_o == $past(dec_vld_i)));

  // R8
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(dec_vld_i)) |-> $stable(dec_bin_o));

endmodule

bind dm1_codec dm1_codec_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enc_bin_i (enc_bin_i),
  .enc_s_o   (enc_s_o),
  .enc_c_o   (enc_c_o),
  .dec_vld_i (dec_vld_i),
  .dec_s_i   (dec_s_i),
  .dec_c_i   (dec_c_i),
  .dec_vld_o (dec_vld_o),
  .dec_bin_o (dec_bin_o)
);

// File: tb/dm1_codec_bench.sv
`timescale 1ns/1ps
module dm1_codec_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic vld;
  logic pm;
  logic [3:0] ps, pc;
  logic [1:0] b1; logic [2:0] b2; logic [4:0] b4; logic [8:0] b8;
  logic       s1, c1;
  logic [1:0] s2, c2;
  logic [3:0] s4, c4, ds4, dc4;
  logic [7:0] s8, c8;
  logic v1, v2, v4, v8;
  logic [1:0] o1; logic [2:0] o2; logic [4:0] o4; logic [8:0] o8;

  assign ds4 = pm ? ps : s4;
  assign dc4 = pm ? pc : c4;

  dm1_codec #(.N(4)) u_dm1_codec (
    .clk(clk), .rst_n(rst_n), .enc_bin_i(b4), .enc_s_o(s4), .enc_c_o(c4),
    .dec_vld_i(vld), .dec_s_i(ds4), .dec_c_i(dc4), .dec_vld_o(v4), .dec_bin_o(o4));
  dm1_codec #(.N(1)) u_dm1_codec_n1 (
    .clk(clk), .rst_n(rst_n), .enc_bin_i(b1), .enc_s_o(s1), .enc_c_o(c1),
    .dec_vld_i(vld), .dec_s_i(s1), .dec_c_i(c1), .dec_vld_o(v1), .dec_bin_o(o1));
  dm1_codec #(.N(2)) u_dm1_codec_n2 (
    .clk(clk), .rst_n(rst_n), .enc_bin_i(b2), .enc_s_o(s2), .enc_c_o(c2),
    .dec_vld_i(vld), .dec_s_i(s2), .dec_c_i(c2), .dec_vld_o(v2), .dec_bin_o(o2));
  dm1_codec #(.N(8)) u_dm1_codec_n8 (
    .clk(clk), .rst_n(rst_n), .enc_bin_i(b8), .enc_s_o(s8), .enc_c_o(c8),
    .dec_vld_i(vld), .dec_s_i(s8), .dec_c_i(c8), .dec_vld_o(v8), .dec_bin_o(o8));

  typedef struct {
    int e1; int e2; int e4; int e8; bit pair;
  } exp_t;

  exp_t sbq[$];
  exp_t got;
  int n_chk = 0;
  int n_bad = 0;
  int last_e4 = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: present one item to all four codecs and log what should come out.
  task automatic push(input int r, input bit pair, input logic [3:0] s, input logic [3:0] c);
    exp_t e;
    @(negedge clk);
    b1 = 2'(r % 3); b2 = 3'(r % 5); b4 = 5'(r % 17); b8 = 9'(r % 257);
    pm = pair; ps = s; pc = c; vld = 1'b1;
    e.e1 = r % 3; e.e2 = r % 5; e.e8 = r % 257; e.pair = pair;
    e.e4 = pair ? ((32'(s) + 1 + 32'(c) + 1) % 17) : (r % 17);
    last_e4 = e.e4;
    sbq.push_back(e);
  endtask

  // Monitor: pops one expectation per valid result.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && v4) begin
      if (sbq.size() == 0) begin
        check("R7 result without pending item", 1, 0);
      end else begin
        got = sbq.pop_front();
        if (got.pair) begin
          if (got.e4 == 0 || got.e4 == 16) check("R5 pair edge N=4", int'(o4), got.e4);
          else check("R4 pair N=4", int'(o4), got.e4);
        end else begin
          check("R6 round trip N=4", int'(o4), got.e4);
        end
        check("R6 round trip N=1", int'(o1), got.e1);
        check("R6 round trip N=2", int'(o2), got.e2);
        check("R6 round trip N=8", int'(o8), got.e8);
        check("R7 valid lockstep", int'({v1, v2, v8}), 7);
      end
    end
  end

  initial begin
    vld = 1'b0; pm = 1'b0; ps = '0; pc = '0;
    b1 = '0; b2 = '0; b4 = '0; b8 = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 valid in reset", int'(v4), 0);
    check("R9 output in reset", int'(o4), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R9 valid after reset", int'(v4), 0);
    check("R9 output after reset", int'(o4), 0);

    // Encoder corner values
    b4 = 5'd13; #1;
    check("R1 s for 13", int'(s4), 13);
    check("R2 c for 13", int'(c4), 15);
    b4 = 5'd16; #1;
    check("R1 s for 16", int'(s4), 0);
    check("R2 c for 16", int'(c4), 14);
    b4 = 5'd0; #1;
    check("R3 s for 0", int'(s4), 0);
    check("R3 c for 0", int'(c4), 15);
    b1 = 2'd2; #1;
    check("R2 N=1 c for 2", int'(c1), 0);
    check("R1 N=1 s for 2", int'(s1), 0);
    b1 = 2'd1; #1;
    check("R2 N=1 c for 1", int'(c1), 1);

    for (int r = 0; r <= 256; r++) push(r, 1'b0, 4'd0, 4'd0);
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) push(s * 16 + c, 1'b1, 4'(s), 4'(c));
    @(negedge clk);
    vld = 1'b0;
    while (sbq.size() != 0) @(negedge clk);

    // Strobe low: change the pair, output must not move
    pm = 1'b1; ps = 4'd0; pc = 4'd15;
    repeat (2) @(negedge clk);
    ps = 4'd7; pc = 4'd3;
    @(negedge clk);
    #1;
    check("R8 hold output", int'(o4), last_e4);
    check("R8 valid low", int'(v4), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule